// File: doc/BRIEF.md
# Four-Way Byte Rounding Averager

This block is a vector datapath unit for two-dimensional half-pixel interpolation in motion compensation. Each operation takes four 64-bit words, each holding eight unsigned byte lanes. For every lane it adds the four bytes in a wider sum, adds a rounding constant of two and divides by four. The eight results are packed into one output word. Because the four samples are combined in one step, the result is rounded only once. A chain of two-input averages would round twice and could be off by one.

An operation is offered with a valid strobe and a guard bit. Only an operation with both set produces a result. The result comes out a fixed number of cycles later with a result-valid flag, and a new operation can be accepted every cycle. The latency is a parameter from one to four cycles. The summing structure can be a balanced tree or a linear chain, selected by a parameter.

Top module: `quad_avg_unit`

## Requirements
- R1: For every lane i, output bits [8i+7:8i] equal floor((a_i + b_i + c_i + d_i + 2) / 4), where a_i..d_i are bits [8i+7:8i] of the four operands.
- R2: An operation accepted at a rising edge shows its result with `res_valid` high after exactly PIPE_DEPTH rising edges (default 2). Operations may be offered on consecutive cycles, and each one produces its own result.
- R3: No intermediate overflow occurs: four 0xFF bytes give 0xFF and four 0x00 bytes give 0x00. Every lane result lies between the smallest and the largest of its four inputs.
- R4: Rounding is half-up on the quarter. Lane sums of 1, 2, 3 and 6 give 0, 1, 1 and 2.
- R5: An operation with `op_guard` low produces no result. `res_valid` stays low in its slot and `res_word` keeps the last result written.
- R6: A cycle with `op_valid` low produces no result. `res_valid` stays low in its slot and `res_word` keeps its value.
- R7: After reset, `res_valid` is 0 and `res_word` is 0.
- R8: Lanes are independent. No carry or value passes from one lane into another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation offered this cycle |
| op_guard | input | 1 | Operation enable; low suppresses the result write |
| src_a | input | 64 | First operand, eight unsigned byte lanes |
| src_b | input | 64 | Second operand |
| src_c | input | 64 | Third operand |
| src_d | input | 64 | Fourth operand |
| res_valid | output | 1 | Result written this cycle |
| res_word | output | 64 | Eight averaged bytes; holds the last written result |

## Verification
The hardest case to reach is a suppressed operation sitting between two live ones in a back-to-back stream. Its slot must stay invalid, and the held output must not take data from it, even though the pipeline registers behind it are still moving. Random stimulus draws the valid and guard bits independently on every cycle, with the guard low about a quarter of the time. Suppressed slots therefore fall between live results in many arrangements, and the output word is compared in every cycle, not only when a result is valid. The rounding boundaries and the all-0xFF overflow case would almost never come up by chance, so directed operations cover them.

// File: rtl/qavg_pkg.sv
package qavg_pkg;
   localparam int unsigned GUARD_BITS = 2;

   function automatic int unsigned sum_width(input int unsigned lane_w);
      return lane_w + GUARD_BITS;
   endfunction

   typedef enum logic [0:0] {
      TREE_BALANCED = 1'b0,
      TREE_CHAIN    = 1'b1
   } tree_shape_e;
endpackage

// File: rtl/qavg_lane.sv
module qavg_lane
   import qavg_pkg::*;
#(
   parameter int unsigned LANE_W = 8,
   parameter tree_shape_e SHAPE  = TREE_BALANCED
) (
   input  logic [LANE_W-1:0] in_a,
   input  logic [LANE_W-1:0] in_b,
   input  logic [LANE_W-1:0] in_c,
   input  logic [LANE_W-1:0] in_d,
   output logic [LANE_W-1:0] avg
);
   localparam int unsigned SW = sum_width(LANE_W);
   localparam logic [SW-1:0] HALF = SW'(2);

   logic [SW-1:0] total;

   generate
      if (SHAPE == TREE_BALANCED) begin : g_tree
         logic [LANE_W:0] pair_ab;
         logic [LANE_W:0] pair_cd;
         always_comb begin
            pair_ab = {1'b0, in_a} + {1'b0, in_b};
            pair_cd = {1'b0, in_c} + {1'b0, in_d};
            total   = {1'b0, pair_ab} + {1'b0, pair_cd};
         end
      end else begin : g_chain
         always_comb begin
            total = SW'(in_a) + SW'(in_b);
            total = total + SW'(in_c);
            total = total + SW'(in_d);
         end
      end
   endgenerate

   logic [SW-1:0] rounded;
   always_comb rounded = total + HALF;
   assign avg = rounded[SW-1:GUARD_BITS];
endmodule

// File: rtl/qavg_pipe.sv
module qavg_pipe #(
   parameter int unsigned WIDTH = 64,
   parameter int unsigned DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_fire,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_fire,
   output logic [WIDTH-1:0] out_data
);
   logic [DEPTH-1:0] fire_q;
   logic [WIDTH-1:0] data_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fire_q <= '0;
         for (int i = 0; i < int'(DEPTH); i++) data_q[i] <= '0;
      end else begin
         fire_q[0] <= in_fire;
         if (in_fire) data_q[0] <= in_data;
         for (int i = 1; i < int'(DEPTH); i++) begin
            fire_q[i] <= fire_q[i-1];
            if (fire_q[i-1]) data_q[i] <= data_q[i-1];
         end
      end
   end

   assign out_fire = fire_q[DEPTH-1];
   assign out_data = data_q[DEPTH-1];
endmodule

// File: rtl/quad_avg_unit.sv
module quad_avg_unit
   import qavg_pkg::*;
#(
   parameter int unsigned LANES      = 8,
   parameter int unsigned LANE_W     = 8,
   parameter int unsigned PIPE_DEPTH = 2,
   parameter tree_shape_e SHAPE      = TREE_BALANCED
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      op_valid,
   input  logic                      op_guard,
   input  logic [LANES*LANE_W-1:0]   src_a,
   input  logic [LANES*LANE_W-1:0]   src_b,
   input  logic [LANES*LANE_W-1:0]   src_c,
   input  logic [LANES*LANE_W-1:0]   src_d,
   output logic                      res_valid,
   output logic [LANES*LANE_W-1:0]   res_word
);
   localparam int unsigned VEC_W = LANES * LANE_W;

   generate
      if (PIPE_DEPTH < 1 || PIPE_DEPTH > 4) begin : g_bad_depth
         $error("quad_avg_unit: PIPE_DEPTH must lie in 1..4");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("quad_avg_unit: LANES must be at least 1");
      end
      if (LANE_W < 2) begin : g_bad_width
         $error("quad_avg_unit: LANE_W must be at least 2");
      end
   endgenerate

   logic             fire;
   logic [VEC_W-1:0] avg_now;

   assign fire = op_valid & op_guard;

   generate
      for (genvar ln = 0; ln < int'(LANES); ln++) begin : g_lane
         qavg_lane #(
            .LANE_W (LANE_W),
            .SHAPE  (SHAPE)
         ) u_lane (
            .in_a (src_a[ln*LANE_W +: LANE_W]),
            .in_b (src_b[ln*LANE_W +: LANE_W]),
            .in_c (src_c[ln*LANE_W +: LANE_W]),
            .in_d (src_d[ln*LANE_W +: LANE_W]),
            .avg  (avg_now[ln*LANE_W +: LANE_W])
         );
      end
   endgenerate

   qavg_pipe #(
      .WIDTH (VEC_W),
      .DEPTH (PIPE_DEPTH)
   ) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_fire  (fire),
      .in_data  (avg_now),
      .out_fire (res_valid),
      .out_data (res_word)
   );
endmodule

// File: rtl/quad_avg_unit_chk.sv
module quad_avg_unit_chk #(
   parameter int unsigned LANES      = 8,
   parameter int unsigned LANE_W     = 8,
   parameter int unsigned PIPE_DEPTH = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    op_valid,
   input logic                    op_guard,
   input logic [LANES*LANE_W-1:0] src_a,
   input logic [LANES*LANE_W-1:0] src_b,
   input logic [LANES*LANE_W-1:0] src_c,
   input logic [LANES*LANE_W-1:0] src_d,
   input logic [LANES*LANE_W-1:0] avg_now,
   input logic                    res_valid,
   input logic [LANES*LANE_W-1:0] res_word
);
   logic [PIPE_DEPTH-1:0] acc_hist;
   logic [3:0]            pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_hist <= '0;
         pending  <= '0;
      end else begin
         acc_hist[0] <= op_valid & op_guard;
         for (int i = 1; i < int'(PIPE_DEPTH); i++) acc_hist[i] <= acc_hist[i-1];
         pending <= pending + 4'(op_valid & op_guard) - 4'(res_valid);
      end
   end

   // R2: a result leaves exactly PIPE_DEPTH edges after acceptance
   assert_fire_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid == acc_hist[PIPE_DEPTH-1]);

   // R2: never more results in flight than pipeline stages
   assert_in_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pending <= 4'(PIPE_DEPTH));

   // R5 / R6: output word only moves when a result is written
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> $stable(res_word));

   // R6: a cycle without valid cannot create a result later
   assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && PIPE_DEPTH == 1) |-> $past(op_valid));

   // R3: each lane average lies within its four inputs
   always_comb begin
      if (rst_n) begin
         for (int ln = 0; ln < int'(LANES); ln++) begin
            automatic logic [LANE_W-1:0] va = src_a[ln*LANE_W +: LANE_W];
            automatic logic [LANE_W-1:0] vb = src_b[ln*LANE_W +: LANE_W];
            automatic logic [LANE_W-1:0] vc = src_c[ln*LANE_W +: LANE_W];
            automatic logic [LANE_W-1:0] vd = src_d[ln*LANE_W +: LANE_W];
            automatic logic [LANE_W-1:0] vr = avg_now[ln*LANE_W +: LANE_W];
            automatic logic [LANE_W-1:0] lo = va;
            automatic logic [LANE_W-1:0] hi = va;
            if (vb < lo) lo = vb;
            if (vc < lo) lo = vc;
            if (vd < lo) lo = vd;
            if (vb > hi) hi = vb;
            if (vc > hi) hi = vc;
            if (vd > hi) hi = vd;
            assert_lane_bounds_R3: assert (vr >= lo && vr <= hi);
         end
      end
   end
endmodule

bind quad_avg_unit quad_avg_unit_chk #(
   .LANES      (LANES),
   .LANE_W     (LANE_W),
   .PIPE_DEPTH (PIPE_DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_guard  (op_guard),
   .src_a     (src_a),
   .src_b     (src_b),
   .src_c     (src_c),
   .src_d     (src_d),
   .avg_now   (avg_now),
   .res_valid (res_valid),
   .res_word  (res_word)
);

// File: tb/quad_avg_unit_tb.sv
`timescale 1ns/1ps
module quad_avg_unit_tb;
   localparam int LAT   = 2;
   localparam int SLOTS = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_guard = 1'b0;
   logic [63:0] src_a = '0, src_b = '0, src_c = '0, src_d = '0;
   logic        res_valid;
   logic [63:0] res_word;

   always #2.5 clk = ~clk;

   quad_avg_unit #(.PIPE_DEPTH(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_guard(op_guard),
      .src_a(src_a), .src_b(src_b), .src_c(src_c), .src_d(src_d),
      .res_valid(res_valid), .res_word(res_word)
   );

   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   bit          done = 0;
   logic        exp_v [SLOTS];
   logic [63:0] exp_d [SLOTS];
   string       exp_tag [SLOTS];
   logic [63:0] model_out = '0;

   function automatic logic [63:0] ref_avg(input logic [63:0] a, b, c, d);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) begin
         int s;
         s = int'(a[8*i +: 8]) + int'(b[8*i +: 8]) + int'(c[8*i +: 8]) + int'(d[8*i +: 8]);
         r[8*i +: 8] = 8'((s + 2) / 4);
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic av, ev, input logic [63:0] ad, ed);
      checks++;
      if (av !== ev || ad !== ed) begin
         errors++;
         $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h", tag, av, ad, ev, ed);
      end
   endtask

   task automatic step(input logic v, g, input logic [63:0] a, b, c, d, input string tag);
      @(negedge clk);
      if (exp_v[cyc]) model_out = exp_d[cyc];
      check(exp_tag[cyc], res_valid, exp_v[cyc], res_word, model_out);
      op_valid = v; op_guard = g;
      src_a = a; src_b = b; src_c = c; src_d = d;
      exp_v[cyc+LAT]   = v & g;
      exp_d[cyc+LAT]   = ref_avg(a, b, c, d);
      exp_tag[cyc+LAT] = (v & g) ? tag : (v ? "R5" : "R6");
      cyc++;
   endtask

   initial begin
      for (int i = 0; i < SLOTS; i++) begin
         exp_v[i] = 1'b0; exp_d[i] = '0; exp_tag[i] = "R7";
      end
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R7: reset state
      check("R7", res_valid, 1'b0, res_word, 64'h0);
      rst_n = 1'b1;
      // R3: overflow and zero corners
      step(1, 1, {8{8'hFF}}, {8{8'hFF}}, {8{8'hFF}}, {8{8'hFF}}, "R3");
      step(1, 1, '0, '0, '0, '0, "R3");
      step(1, 1, {8{8'hFF}}, {8{8'hFE}}, {8{8'hFF}}, {8{8'hFF}}, "R3");
      // R4: lane sums 1,2,3,6 and mixed per lane
      step(1, 1, {8{8'h01}}, '0, '0, '0, "R4");
      step(1, 1, {8{8'h01}}, {8{8'h01}}, '0, '0, "R4");
      step(1, 1, {8{8'h01}}, {8{8'h01}}, {8{8'h01}}, '0, "R4");
      step(1, 1, {8{8'h02}}, {8{8'h02}}, {8{8'h01}}, {8{8'h01}}, "R4");
      // R5: guard low between live operations, data differs
      step(1, 0, {8{8'h80}}, {8{8'h80}}, {8{8'h80}}, {8{8'h80}}, "R5");
      step(1, 1, {8{8'h10}}, {8{8'h20}}, {8{8'h30}}, {8{8'h40}}, "R1");
      step(1, 0, {8{8'hAA}}, '0, '0, '0, "R5");
      step(1, 0, {8{8'h55}}, '0, '0, '0, "R5");
      // R6: valid low with guard high
      step(0, 1, {8{8'h77}}, {8{8'h77}}, {8{8'h77}}, {8{8'h77}}, "R6");
      step(0, 0, {8{8'h33}}, '0, '0, '0, "R6");
      // R8: lane independence, neighbour lanes at extremes
      step(1, 1, 64'hFF00FF00FF00FF00, 64'hFF00FF00FF00FF00, 64'hFF01FF01FF01FF01,
           64'hFF01FF01FF01FF01, "R8");
      step(1, 1, 64'h0001020304050607, 64'h08090A0B0C0D0E0F, 64'hF0E0D0C0B0A09080,
           64'h7F7E7D7C7B7A7978, "R8");
      // R2: back-to-back random stream, every cycle valid
      for (int k = 0; k < 200; k++)
         step(1, 1, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom}, "R2");
      // R1 with random valid/guard mix (R5 / R6 slots interleaved)
      for (int k = 0; k < 600; k++) begin
         logic v, g;
         v = ($urandom % 5) != 0;
         g = ($urandom % 4) != 0;
         step(v, g, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom}, "R1");
      end
      // drain
      for (int k = 0; k < LAT + 2; k++) step(0, 0, '0, '0, '0, '0, "R6");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule